// File: doc/BRIEF.md
# EEPROM Status and Write-Protect Controller

This block keeps the status state of a 256-byte serial EEPROM: the write enable latch, the write-in-progress flag and a two-bit block-protect code. It takes single-cycle requests from a command front-end. These requests set or clear the write enable, replace the protect code, or write one byte at an address. It tests each byte write against the protected address range. An accepted write runs as a timed internal cycle. At the end of that cycle the block pulses a write strobe to the memory array, or it commits the new protect code.

The front-end reads an 8-bit status byte at any time. While a protect-code update is in flight, the status byte still shows the old code, and the latch and busy flags show their live values. Keeping the code across power cycles is modelled here as a plain register with a parameterised reset value.

The write cycle is run by a state machine with three states:
- `ST_IDLE`: waiting for a request.
- `ST_ARR_BUSY`: an array byte write is running.
- `ST_STAT_BUSY`: a protect-code write is running.

Its transitions are:
- `ST_IDLE → ST_ARR_BUSY`: an accepted byte write.
- `ST_IDLE → ST_STAT_BUSY`: an accepted status write.
- `ST_ARR_BUSY → ST_IDLE`: the cycle counter reaches zero. In that last cycle the strobe fires.
- `ST_STAT_BUSY → ST_IDLE`: the cycle counter reaches zero. The new code is committed on that edge.
- `ST_IDLE → ST_IDLE`: any other case, including refused or dropped requests and write-enable changes.

Top module: `eeprom_status_ctrl`

## Requirements
- R1: `status_out` bits 7..4 are always 1. Bits 3..2 hold the protect code, with bit 3 as its high bit. Bit 1 is the write enable latch (WEL) and bit 0 is the busy flag (WIP). After reset the byte reads 0xF0, given the default protect code of 00.
- R2: While idle, `req_set_we` sets WEL and `req_clr_we` clears it, both visible one cycle later.
- R3: A byte write or a status write issued while WEL is 0 is refused. WIP stays 0, no strobe appears, and the protect code is unchanged.
- R4: The protect code selects the protected addresses. Code 00 protects nothing. Code 01 protects 0xC0..0xFF. Code 10 protects 0x80..0xFF. Code 11 protects 0x00..0xFF.
- R5: A byte write to a protected address is dropped. No cycle starts, no strobe appears, and WEL stays 1.
- R6: An accepted write raises WIP in the next cycle. WIP then stays high for exactly `WR_CYCLES` cycles. When WIP falls, WEL is 0 as well.
- R7: An accepted byte write gives exactly one `arr_we` pulse, in the last WIP cycle. During that pulse `arr_addr` and `arr_wdata` carry the address and data captured at acceptance.
- R8: A status write reports the old protect code for its whole cycle and never pulses `arr_we`. The new code (from `stat_bp_in`) appears in the cycle WIP falls. During a byte write, the code shown is the current one.
- R9: While WIP is 1, all four requests are ignored, including set and clear of WEL.
- R10: While idle, only the highest-priority request present is acted on, even if it is then refused. The order from highest to lowest is byte write, status write, clear WEL, set WEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_we | input | 1 | Request: set write enable latch |
| req_clr_we | input | 1 | Request: clear write enable latch |
| req_wr_stat | input | 1 | Request: write protect code |
| stat_bp_in | input | 2 | New protect code for a status write |
| req_wr_byte | input | 1 | Request: write one array byte |
| byte_addr | input | 8 | Byte write address |
| byte_data | input | 8 | Byte write data |
| status_out | output | 8 | Status byte {1111, code, WEL, WIP} |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench tests addresses on both sides of each protect boundary (0x7F/0x80, 0xBF/0xC0, 0x00/0xFF) under every code. A decoder that was off by one region would either strobe a protected byte or refuse a free one. It also fires clear, set and write requests into a running cycle. A design that honoured any of them would drop WEL early or emit a second strobe with the wrong address. Status writes are checked cycle by cycle to show that the old code stays on view until WIP falls; committing early would show the new code while busy. A WIP length counted from the wrong edge would show up as a window of `WR_CYCLES`±1 cycles.

// File: rtl/esr_pkg.sv
package esr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARR_BUSY,
        ST_STAT_BUSY
    } wr_state_e;

    localparam logic [3:0] STAT_FILL = 4'hF;

endpackage

// File: rtl/prot_range_chk.sv
module prot_range_chk #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [1:0] region;

    assign region = addr[ADDR_W-1 -: 2];

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (region == 2'b11);
            2'b10:   hit = region[1];
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wr_cycle_fsm.sv
module wr_cycle_fsm
    import esr_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         WR_CYCLES = 1000,
    parameter logic [1:0] BP_INIT   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              wr_stat,
    input  logic [1:0]        stat_bp,
    input  logic              wr_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              prot_hit,
    output logic              wel,
    output logic              wip,
    output logic [1:0]        bp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);

    localparam int          CW       = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(WR_CYCLES - 1);

    wr_state_e         state, state_nx;
    logic [CW-1:0]     cnt;
    logic              wel_q;
    logic [1:0]        bp_q, bp_pend;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              last;
    logic              take_byte, take_stat;

    assign last      = (cnt == '0);
    assign take_byte = wr_byte && wel_q && !prot_hit;
    assign take_stat = !wr_byte && wr_stat && wel_q;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_byte)      state_nx = ST_ARR_BUSY;
                else if (take_stat) state_nx = ST_STAT_BUSY;
            end
            ST_ARR_BUSY:  if (last) state_nx = ST_IDLE;
            ST_STAT_BUSY: if (last) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register with its datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            wel_q   <= 1'b0;
            bp_q    <= BP_INIT;
            bp_pend <= BP_INIT;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (wr_byte) begin
                        if (take_byte) begin
                            addr_q <= addr;
                            data_q <= data;
                            cnt    <= CNT_LOAD;
                        end
                    end else if (wr_stat) begin
                        if (take_stat) begin
                            bp_pend <= stat_bp;
                            cnt     <= CNT_LOAD;
                        end
                    end else if (clr_we) begin
                        wel_q <= 1'b0;
                    end else if (set_we) begin
                        wel_q <= 1'b1;
                    end
                end
                ST_ARR_BUSY: begin
                    if (last) wel_q <= 1'b0;
                    else      cnt   <= cnt - CW'(1);
                end
                ST_STAT_BUSY: begin
                    if (last) begin
                        wel_q <= 1'b0;
                        bp_q  <= bp_pend;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wel      = wel_q;
        bp       = bp_q;
        wip      = (state != ST_IDLE);
        arr_we   = (state == ST_ARR_BUSY) && last;
        arr_addr = addr_q;
        arr_data = data_q;
    end

endmodule

// File: rtl/eeprom_status_ctrl.sv
module eeprom_status_ctrl
    import esr_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         WR_CYCLES = 1000,
    parameter logic [1:0] BP_INIT   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_set_we,
    input  logic              req_clr_we,
    input  logic              req_wr_stat,
    input  logic [1:0]        stat_bp_in,
    input  logic              req_wr_byte,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_data,
    output logic [7:0]        status_out,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    logic       prot_hit;
    logic       wel, wip;
    logic [1:0] bp;

    prot_range_chk #(.ADDR_W(ADDR_W)) u_prot (
        .bp   (bp),
        .addr (byte_addr),
        .hit  (prot_hit)
    );

    wr_cycle_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .WR_CYCLES (WR_CYCLES),
        .BP_INIT   (BP_INIT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (req_set_we),
        .clr_we   (req_clr_we),
        .wr_stat  (req_wr_stat),
        .stat_bp  (stat_bp_in),
        .wr_byte  (req_wr_byte),
        .addr     (byte_addr),
        .data     (byte_data),
        .prot_hit (prot_hit),
        .wel      (wel),
        .wip      (wip),
        .bp       (bp),
        .arr_we   (arr_we),
        .arr_addr (arr_addr),
        .arr_data (arr_wdata)
    );

    assign status_out = {STAT_FILL, bp, wel, wip};

endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        status_out,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    logic        wip, wel;
    logic [1:0]  bp;
    logic [1:0]  top2;
    logic        addr_locked;
    logic [31:0] wip_len;

    assign wip  = status_out[0];
    assign wel  = status_out[1];
    assign bp   = status_out[3:2];
    assign top2 = arr_addr[ADDR_W-1 -: 2];
    assign addr_locked = (bp == 2'b11) || (bp == 2'b10 && top2[1]) ||
                         (bp == 2'b01 && top2 == 2'b11);

    always_ff @(posedge clk) begin
        if (!rst_n)   wip_len <= '0;
        else if (wip) wip_len <= wip_len + 32'd1;
        else          wip_len <= '0;
    end

    // R1
    fill_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[7:4] == 4'hF);

    // R7
    strobe_in_wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wip);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);

    // R5
    strobe_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !addr_locked);

    // R3
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    // R6
    end_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R6
    wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (wip_len == 32'(WR_CYCLES)));

    // R8
    bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> $stable(bp));

    // R9
    wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> $stable(wel));

endmodule

bind eeprom_status_ctrl esr_checker #(
    .ADDR_W    (ADDR_W),
    .WR_CYCLES (WR_CYCLES)
) u_esr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_out (status_out),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr)
);

// File: tb/test_eeprom_status_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_status_ctrl;

    localparam int TB_WR = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_set_we = 0, req_clr_we = 0, req_wr_stat = 0, req_wr_byte = 0;
    logic [1:0] stat_bp_in = 0;
    logic [7:0] byte_addr = 0, byte_data = 0;
    logic [7:0] status_out;
    logic       arr_we;
    logic [7:0] arr_addr, arr_wdata;

    int n_chk = 0, n_fail = 0;
    logic [1:0] e_bp = 2'b00;
    logic       e_wel = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_status_ctrl #(.WR_CYCLES(TB_WR)) i_eeprom_status_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_set_we(req_set_we), .req_clr_we(req_clr_we),
        .req_wr_stat(req_wr_stat), .stat_bp_in(stat_bp_in),
        .req_wr_byte(req_wr_byte), .byte_addr(byte_addr), .byte_data(byte_data),
        .status_out(status_out), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    function automatic bit locked(input logic [1:0] bp, input logic [7:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 8'hC0;
            2'b10:   return a >= 8'h80;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] idle_status();
        return {4'hF, e_bp, e_wel, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drop_all();
        req_set_we = 0; req_clr_we = 0; req_wr_stat = 0; req_wr_byte = 0;
    endtask

    // reqs = {byte, stat, clr, set}
    task automatic issue(input logic [3:0] reqs, input logic [7:0] a, input logic [7:0] d, input logic [1:0] nbp);
        @(negedge clk);
        {req_wr_byte, req_wr_stat, req_clr_we, req_set_we} = reqs;
        byte_addr = a; byte_data = d; stat_bp_in = nbp;
        @(negedge clk);
        drop_all();
    endtask

    task automatic run_cycle(input bit is_arr, input logic [7:0] a, input logic [7:0] d,
                             input logic [1:0] nbp, input bit inject);
        int wip_n = 0, we_n = 0, we_pos = -1;
        while (status_out[0] && wip_n < 4*TB_WR) begin
            wip_n++;
            chk(status_out[3:2] == e_bp, "R8", status_out[3:2], e_bp);
            if (inject && wip_n == 4)
                chk(status_out[1] == 1'b1, "R9", status_out[1], 1);
            if (arr_we) begin
                we_n++; we_pos = wip_n;
                chk(arr_addr == a && arr_wdata == d, "R7", {arr_addr, arr_wdata}, {a, d});
            end
            if (inject && wip_n == 3) begin
                req_clr_we = 1; req_wr_byte = 1; req_wr_stat = 1;
                byte_addr = a ^ 8'h01; byte_data = ~d; stat_bp_in = ~nbp;
            end
            @(negedge clk);
            drop_all();
        end
        chk(wip_n == TB_WR, "R6", wip_n, TB_WR);
        if (is_arr) chk(we_n == 1 && we_pos == TB_WR, "R7", we_pos, TB_WR);
        else        chk(we_n == 0, "R8", we_n, 0);
        e_wel = 1'b0;
        if (!is_arr) e_bp = nbp;
        chk(status_out == idle_status(), is_arr ? "R6" : "R8", status_out, idle_status());
    endtask

    task automatic do_set();
        issue(4'b0001, 0, 0, 0); e_wel = 1;
        chk(status_out == idle_status(), "R2", status_out, idle_status());
    endtask

    task automatic do_clr();
        issue(4'b0010, 0, 0, 0); e_wel = 0;
        chk(status_out == idle_status(), "R2", status_out, idle_status());
    endtask

    task automatic do_byte(input logic [7:0] a, input logic [7:0] d, input bit inject);
        issue(4'b1000, a, d, 0);
        if (e_wel && !locked(e_bp, a)) begin
            chk(status_out[0] == 1'b1, "R4", status_out, 1);
            run_cycle(1, a, d, 0, inject);
        end else begin
            chk(status_out == idle_status(), e_wel ? "R5" : "R3", status_out, idle_status());
            chk(arr_we == 1'b0, e_wel ? "R5" : "R3", arr_we, 0);
        end
    endtask

    task automatic do_stat(input logic [1:0] nbp);
        issue(4'b0100, 0, 0, nbp);
        if (e_wel) begin
            chk(status_out[0] == 1'b1, "R8", status_out, 1);
            run_cycle(0, 0, 0, nbp, 0);
        end else begin
            chk(status_out == idle_status(), "R3", status_out, idle_status());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_out == 8'hF0, "R1", status_out, 8'hF0);
        chk(arr_we == 1'b0, "R1", arr_we, 0);

        // refused without WEL
        do_byte(8'h10, 8'hA5, 0);
        do_stat(2'b11);
        do_set();
        do_clr();

        // boundaries under every code
        for (int c = 0; c < 4; c++) begin
            do_set(); do_stat(2'(c));
            chk(status_out[3:2] == 2'(c), "R4", status_out[3:2], c);
            do_set(); do_byte(8'h7F, 8'h11, 0);
            do_set(); do_byte(8'h80, 8'h22, 0);
            do_set(); do_byte(8'hBF, 8'h33, 0);
            do_set(); do_byte(8'hC0, 8'h44, 0);
            do_set(); do_byte(8'hFF, 8'h55, 0);
            do_set(); do_byte(8'h00, 8'h66, 0);
        end

        // unprotect, then requests injected mid-cycle
        do_set(); do_stat(2'b00);
        do_set(); do_byte(8'h42, 8'h9C, 1);

        // R10: byte write wins over clr/set
        do_set();
        issue(4'b1011, 8'h05, 8'h77, 0);
        chk(status_out[0] == 1'b1, "R10", status_out, 1);
        run_cycle(1, 8'h05, 8'h77, 0, 0);
        // R10: refused status write still blocks a same-cycle set
        issue(4'b0101, 0, 0, 2'b11);
        chk(status_out == idle_status(), "R10", status_out, idle_status());
        // R10: clear beats set
        do_set();
        issue(4'b0011, 0, 0, 0); e_wel = 0;
        chk(status_out == idle_status(), "R10", status_out, idle_status());

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 4)       do_set();
            else if (op == 4) do_clr();
            else if (op < 9)  do_byte(8'($urandom), 8'($urandom), ($urandom_range(0, 3) == 0));
            else              do_stat(2'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule